// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the operand or branch-target address for a small controller with a 10-bit program space and an 8-bit data space. Each cycle that its input strobe is high, it takes an addressing-mode code, the current program counter, a 10-bit index pointer and up to two operand bytes. One clock edge later it presents a registered result. The result has four parts: the effective address, a flag that tells whether the address targets program space or data space, an immediate-data byte, and an illegal-request flag.

Six modes are covered. Indexed mode adds an unsigned byte offset to the pointer. Direct mode addresses data space with the operand byte. In immediate mode the operand byte is the data value itself. Inherent mode takes no operand. Absolute mode builds a two-byte program target and is legal only for long jumps and subroutine calls. Relative mode gives a short branch target within -31 to +32 of the program counter. All 10-bit sums wrap modulo 1024. Fetch, decode and memory access belong to neighbouring blocks.

Top module: `ea_gen_top`

## Requirements
- R1: `res_vld` is high in exactly the cycle after a cycle in which `req_vld` was high, and is low otherwise. All other outputs carry the result of that request in the same cycle.
- R2: After reset all outputs are zero. While `req_vld` is low, `ea`, `ea_prog`, `imm_out` and `illegal` keep their previous values.
- R3: Indexed mode (code 0): `ea` = (`xptr` + `opnd0`) mod 1024, with `opnd0` unsigned. `ea_prog` equals `idx_prog`, `imm_out` = 0 and `illegal` = 0.
- R4: Direct mode (code 1): `ea` = `opnd0` zero-extended to 10 bits, `ea_prog` = 0 (data space) and `illegal` = 0.
- R5: Immediate mode (code 2): `imm_out` = `opnd0`, `ea` = 0, `ea_prog` = 0. In every other mode `imm_out` = 0.
- R6: Inherent mode (code 3): `ea` = 0, `ea_prog` = 0, `imm_out` = 0 and `illegal` = 0. All operand inputs are ignored.
- R7: Absolute mode (code 4) with `long_xfer` = 1: `ea` = {`opnd0`[1:0], `opnd1`[7:0]}, `ea_prog` = 1 and `illegal` = 0. Bits 7:2 of `opnd0` are ignored.
- R8: Absolute mode (code 4) with `long_xfer` = 0: `illegal` = 1, `ea` = 0 and `ea_prog` = 0.
- R9: Relative mode (code 5): `ea` = (`pc` + `opnd0`[5:0] - 31) mod 1024, so field codes 0..63 give displacements -31..+32. `ea_prog` = 1 and `illegal` = 0. Bits 7:6 of `opnd0` are ignored.
- R10: Reserved mode codes 6 and 7 give `illegal` = 1 with `ea`, `ea_prog` and `imm_out` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| mode | input | 3 | Addressing-mode code |
| long_xfer | input | 1 | Current instruction is a long jump or subroutine call |
| idx_prog | input | 1 | Indexed access targets program space |
| pc | input | 10 | Current program counter |
| xptr | input | 10 | Index pointer, low 10 bits |
| opnd0 | input | 8 | First operand byte |
| opnd1 | input | 8 | Second operand byte |
| res_vld | output | 1 | Result valid |
| ea | output | 10 | Effective address |
| ea_prog | output | 1 | 1 = program space, 0 = data space |
| imm_out | output | 8 | Immediate data value |
| illegal | output | 1 | Illegal mode request |

## Verification
Every result lands one rising edge after the request. The bench drives a request on a falling edge and keeps the strobe high across exactly one rising edge. It drops the strobe and reads all outputs at the next falling edge, which is the first point where the registered result is stable. For the hold checks, the bench changes the inputs with the strobe low, lets further rising edges pass, and compares the outputs against the last accepted result. The reset check reads the outputs at a falling edge while reset is still high.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int PA_W     = 10;
    localparam int DA_W     = 8;
    localparam int HI_W     = PA_W - DA_W;
    localparam int REL_W    = 6;
    localparam int REL_BIAS = 31;
    localparam int MODE_W   = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_INDEXED  = 3'd0,
        AM_DIRECT   = 3'd1,
        AM_IMMED    = 3'd2,
        AM_INHERENT = 3'd3,
        AM_ABSOLUTE = 3'd4,
        AM_RELATIVE = 3'd5
    } ea_mode_e;

    typedef struct packed {
        logic [PA_W-1:0] addr;
        logic            prog;
        logic [DA_W-1:0] imm;
        logic            bad;
    } ea_res_t;

    localparam ea_res_t EA_RES_ZERO = '0;

    function automatic logic [PA_W-1:0] abs_target(input logic [DA_W-1:0] hi,
                                                   input logic [DA_W-1:0] lo);
        return {hi[HI_W-1:0], lo};
    endfunction
endpackage

// File: rtl/ea_wrap_add.sv
module ea_wrap_add #(
    parameter int W = 10
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] plus,
    input  logic [W-1:0] minus,
    output logic [W-1:0] sum
);
    always_comb begin
        sum = base + plus - minus;
    end
endmodule

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              long_xfer,
    input  logic              idx_prog,
    input  logic [DA_W-1:0]   opnd0,
    input  logic [DA_W-1:0]   opnd1,
    input  logic [PA_W-1:0]   idx_sum,
    input  logic [PA_W-1:0]   rel_sum,
    output ea_res_t           res
);
    ea_mode_e m;

    always_comb begin
        m   = ea_mode_e'(mode);
        res = EA_RES_ZERO;
        case (m)
            AM_INDEXED: begin
                res.addr = idx_sum;
                res.prog = idx_prog;
            end
            AM_DIRECT: begin
                res.addr = PA_W'(opnd0);
            end
            AM_IMMED: begin
                res.imm = opnd0;
            end
            AM_INHERENT: begin
                res = EA_RES_ZERO;
            end
            AM_ABSOLUTE: begin
                if (long_xfer) begin
                    res.addr = abs_target(opnd0, opnd1);
                    res.prog = 1'b1;
                end else begin
                    res.bad = 1'b1;
                end
            end
            AM_RELATIVE: begin
                res.addr = rel_sum;
                res.prog = 1'b1;
            end
            default: begin
                res.bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ea_gen_top.sv
module ea_gen_top
    import ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [MODE_W-1:0] mode,
    input  logic              long_xfer,
    input  logic              idx_prog,
    input  logic [PA_W-1:0]   pc,
    input  logic [PA_W-1:0]   xptr,
    input  logic [DA_W-1:0]   opnd0,
    input  logic [DA_W-1:0]   opnd1,
    output logic              res_vld,
    output logic [PA_W-1:0]   ea,
    output logic              ea_prog,
    output logic [DA_W-1:0]   imm_out,
    output logic              illegal
);
    logic [PA_W-1:0] idx_sum;
    logic [PA_W-1:0] rel_sum;
    ea_res_t         nxt;
    ea_res_t         cur;
    logic            vld_q;

    // Indexed: pointer plus unsigned byte, wrapping at the program-space size
    ea_wrap_add #(.W(PA_W)) u_idx_add (
        .base  (xptr),
        .plus  (PA_W'(opnd0)),
        .minus ('0),
        .sum   (idx_sum)
    );

    // Relative: biased 6-bit field gives the asymmetric displacement
    ea_wrap_add #(.W(PA_W)) u_rel_add (
        .base  (pc),
        .plus  (PA_W'(opnd0[REL_W-1:0])),
        .minus (PA_W'(REL_BIAS)),
        .sum   (rel_sum)
    );

    ea_mode_decode u_dec (
        .mode      (mode),
        .long_xfer (long_xfer),
        .idx_prog  (idx_prog),
        .opnd0     (opnd0),
        .opnd1     (opnd1),
        .idx_sum   (idx_sum),
        .rel_sum   (rel_sum),
        .res       (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= EA_RES_ZERO;
            vld_q <= 1'b0;
        end else begin
            vld_q <= req_vld;
            if (req_vld) begin
                cur <= nxt;
            end
        end
    end

    assign res_vld = vld_q;
    assign ea      = cur.addr;
    assign ea_prog = cur.prog;
    assign imm_out = cur.imm;
    assign illegal = cur.bad;

    p_vld_follows_r1: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> res_vld);
    p_vld_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> !res_vld);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> ($stable(ea) && $stable(ea_prog) && $stable(imm_out) && $stable(illegal)));
    p_direct_data_r4: assert property (@(posedge clk) disable iff (rst)
        (req_vld && mode == 3'd1) |=> (!ea_prog && ea == PA_W'($past(opnd0))));
    p_imm_value_r5: assert property (@(posedge clk) disable iff (rst)
        (req_vld && mode == 3'd2) |=> (imm_out == $past(opnd0) && ea == '0));
    p_abs_legal_r7: assert property (@(posedge clk) disable iff (rst)
        (req_vld && mode == 3'd4 && long_xfer) |=> (ea_prog && !illegal && ea[DA_W-1:0] == $past(opnd1)));
    p_abs_bad_r8: assert property (@(posedge clk) disable iff (rst)
        (req_vld && mode == 3'd4 && !long_xfer) |=> (illegal && ea == '0));
    p_rel_prog_r9: assert property (@(posedge clk) disable iff (rst)
        (req_vld && mode == 3'd5) |=> (ea_prog && !illegal));
    p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
        (req_vld && mode[2:1] == 2'b11) |=> (illegal && ea == '0 && !ea_prog));
endmodule

// File: tb/ea_gen_top_tb_top.sv
module ea_gen_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_vld = 1'b0;
    logic [2:0] mode = '0;
    logic       long_xfer = 1'b0;
    logic       idx_prog = 1'b0;
    logic [9:0] pc = '0;
    logic [9:0] xptr = '0;
    logic [7:0] opnd0 = '0;
    logic [7:0] opnd1 = '0;
    logic       res_vld;
    logic [9:0] ea;
    logic       ea_prog;
    logic [7:0] imm_out;
    logic       illegal;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ea_gen_top dut_i (
        .clk(clk), .rst(rst), .req_vld(req_vld), .mode(mode),
        .long_xfer(long_xfer), .idx_prog(idx_prog), .pc(pc), .xptr(xptr),
        .opnd0(opnd0), .opnd1(opnd1), .res_vld(res_vld), .ea(ea),
        .ea_prog(ea_prog), .imm_out(imm_out), .illegal(illegal)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive at falling edge, one rising edge with strobe high, read at next falling edge
    task automatic issue(input int md, input bit lx, input bit ip, input int p,
                         input int x, input int o0, input int o1);
        @(negedge clk);
        mode = 3'(md); long_xfer = lx; idx_prog = ip;
        pc = 10'(p); xptr = 10'(x); opnd0 = 8'(o0); opnd1 = 8'(o1);
        req_vld = 1'b1;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    task automatic expect_res(input string req, input int e_ea, input int e_prog,
                              input int e_imm, input int e_bad);
        chk(req, "res_vld", int'(res_vld), 1);
        chk(req, "ea", int'(ea), e_ea);
        chk(req, "ea_prog", int'(ea_prog), e_prog);
        chk(req, "imm_out", int'(imm_out), e_imm);
        chk(req, "illegal", int'(illegal), e_bad);
    endtask

    task automatic t_reset_r2();
        @(negedge clk);
        chk("R2", "reset ea", int'(ea), 0);
        chk("R2", "reset vld", int'(res_vld), 0);
        chk("R2", "reset flags", int'({ea_prog, illegal}), 0);
        chk("R2", "reset imm", int'(imm_out), 0);
        rst = 1'b0;
    endtask

    task automatic t_indexed_r3();
        issue(0, 0, 0, 5, 100, 20, 0);
        expect_res("R3", 120, 0, 0, 0);
        issue(0, 0, 1, 5, 1000, 255, 0);
        expect_res("R3", 231, 1, 0, 0);
        issue(0, 0, 1, 0, 1023, 1, 0);
        expect_res("R3", 0, 1, 0, 0);
    endtask

    task automatic t_direct_r4();
        issue(1, 1, 1, 77, 900, 8'hC3, 8'h11);
        expect_res("R4", 8'hC3, 0, 0, 0);
    endtask

    task automatic t_immed_r5();
        issue(2, 0, 1, 300, 400, 8'h5A, 8'hFF);
        expect_res("R5", 0, 0, 8'h5A, 0);
    endtask

    task automatic t_inherent_r6();
        issue(3, 1, 1, 512, 700, 8'hFF, 8'hFF);
        expect_res("R6", 0, 0, 0, 0);
    endtask

    task automatic t_absolute_r7();
        issue(4, 1, 0, 12, 0, 8'hFE, 8'h34);
        expect_res("R7", 512 + 8'h34, 1, 0, 0);
        issue(4, 1, 0, 12, 0, 8'h03, 8'hFF);
        expect_res("R7", 1023, 1, 0, 0);
    endtask

    task automatic t_abs_bad_r8();
        issue(4, 0, 1, 12, 0, 8'h03, 8'h55);
        expect_res("R8", 0, 0, 0, 1);
    endtask

    task automatic t_relative_r9();
        issue(5, 0, 0, 0, 0, 0, 0);
        expect_res("R9", 993, 1, 0, 0);
        issue(5, 0, 0, 1023, 0, 63, 0);
        expect_res("R9", 31, 1, 0, 0);
        issue(5, 0, 0, 400, 0, 8'hC0 | 31, 0);
        expect_res("R9", 400, 1, 0, 0);
        issue(5, 0, 0, 400, 0, 63, 0);
        expect_res("R9", 432, 1, 0, 0);
    endtask

    task automatic t_reserved_r10();
        issue(6, 1, 1, 3, 3, 8'h77, 8'h77);
        expect_res("R10", 0, 0, 0, 1);
        issue(7, 1, 1, 3, 3, 8'h77, 8'h77);
        expect_res("R10", 0, 0, 0, 1);
    endtask

    task automatic t_hold_r1_r2();
        issue(1, 0, 0, 0, 0, 8'h42, 0);
        @(negedge clk);
        mode = 3'd2; opnd0 = 8'h99; xptr = 10'd555;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "vld low after idle", int'(res_vld), 0);
        chk("R2", "ea held", int'(ea), 8'h42);
        chk("R2", "imm held", int'(imm_out), 0);
        chk("R2", "prog held", int'(ea_prog), 0);
    endtask

    initial begin
        t_reset_r2();
        t_indexed_r3();
        t_direct_r4();
        t_immed_r5();
        t_inherent_r6();
        t_absolute_r7();
        t_abs_bad_r8();
        t_relative_r9();
        t_reserved_r10();
        t_hold_r1_r2();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule